// File: doc/BRIEF.md
# Machine Status Register with Supervisor View

This block holds the machine-level status register of a 64-bit core and presents it through two windows. The machine window shows every implemented field. The supervisor window reads and writes the same storage, but it exposes only the fields a supervisor may see. Every write passes through legalization before it is stored. Legalization keeps the register-width fields fixed, keeps the user previous-interrupt-enable bit at zero, and rejects the reserved previous-privilege code. The summary-dirty bit is not stored: it is computed on every read from the two extension-state fields.

From the stored state and the current privilege level, the block also drives three controls. The first is the register-width encoding in force at the current privilege level. The second tells whether the address-translation fence instruction is illegal. The third is the address-translation mode that the memory unit must use.

A parameter selects a 64-bit or a 32-bit configuration. In the 32-bit configuration the width fields are absent from the register. Supervisor and user levels then always report the 32-bit encoding.

Top module: `mstat_csr`

## Requirements
- R1: While reset is applied, every stored field clears to zero. In the 64-bit configuration the supervisor width field (bits 35:34) and the user width field (bits 33:32) load the value of `misa_mxl`. A machine-view read after reset therefore shows only those two fields.
- R2: No write through either view changes the supervisor width field or the user width field. A later change of `misa_mxl` does not change them either.
- R3: Bit 4, the user previous-interrupt-enable bit, reads as 0 in both views after any write.
- R4: Bit XLEN-1 reads as 1 exactly when the bits 16:15 field or the bits 14:13 field holds 2'b11; otherwise it reads as 0.
- R5: A machine-view write takes effect at the next clock edge and updates these bits: 0, 1, 3, 5, 7, 8, 12:11, 14:13, 16:15, 17, 18, 19, 20, 21 and 22. Bits 2, 6, 9 and 10 stay zero. If the written value of bits 12:11 is 2'b10, those bits keep their previous value.
- R6: A supervisor-view read returns bit XLEN-1, bits 33:32 (64-bit only), 19, 18, 16:15, 14:13, 8, 5, 4, 1 and 0 from the stored register. Every other bit reads as 0.
- R7: A supervisor-view write updates only bits 19, 18, 16:15, 14:13, 8, 5, 1 and 0. All other stored bits keep their values.
- R8: `eff_xl` equals `misa_mxl` when `cur_priv` is 2'b11 (machine, and also for the unused code 2'b10). It equals the supervisor width field for 2'b01 (supervisor) and the user width field for 2'b00 (user). The width codes are 2'b01 for 32-bit and 2'b10 for 64-bit.
- R9: `fence_illegal` is 1 in user mode. It is also 1 in supervisor mode when bit 20 (the trap-translation bit) is set and the supervisor width field is 2'b10. In every other case it is 0.
- R10: `xlat_mode` is 0 (bare) in machine mode. In supervisor or user mode it equals `satp_mode` when the supervisor width field is 2'b10, and otherwise it equals `{3'b000, satp_mode[0]}`.
- R11: In the 32-bit configuration the width fields do not exist. Reads show no width bits, bit 31 is the summary-dirty bit, and `eff_xl` is 2'b01 for supervisor and user.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Write strobe for the selected view |
| csr_sel_sup | input | 1 | 1 selects the supervisor view, 0 selects the machine view |
| csr_wdata | input | XLEN | Write data |
| cur_priv | input | 2 | Current privilege level: 00 user, 01 supervisor, 11 machine |
| misa_mxl | input | 2 | Machine width field from the ISA register |
| satp_mode | input | 4 | Mode field of the translation base register |
| csr_rdata | output | XLEN | Read data of the selected view (combinational) |
| eff_xl | output | 2 | Register-width encoding at the current privilege level |
| fence_illegal | output | 1 | Address-translation fence is illegal |
| xlat_mode | output | 4 | Address-translation mode in effect |

## Verification
The bench builds two copies of the block, one with XLEN 64 and one with XLEN 32, driven from the same privilege and translation-mode inputs. The 64-bit copy exercises the stored width fields, the rule that they ignore writes and later changes of the machine width input, and the translation mode taken directly from the 4-bit mode field. The 32-bit copy exercises the configuration without width fields: the summary-dirty bit sits at bit 31, supervisor and user report the 32-bit code, the trap-translation bit does not affect fence legality, and the translation mode follows only bit 0 of the mode field.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    localparam logic [1:0] XL_32 = 2'b01;
    localparam logic [1:0] XL_64 = 2'b10;
    localparam logic [1:0] EXT_DIRTY = 2'b11;
    localparam logic [1:0] MPP_RSV = 2'b10;

    // Width of the stored low portion (bits 22:0).
    localparam int LOW_W = 23;

    localparam int B_UPIE   = 4;
    localparam int B_MPP_LO = 11;
    localparam int B_MPP_HI = 12;
    localparam int B_FS_LO  = 13;
    localparam int B_FS_HI  = 14;
    localparam int B_XS_LO  = 15;
    localparam int B_XS_HI  = 16;
    localparam int B_TVM    = 20;

    // Machine-writable bits: 0,1,3,5,7,8,11-22.
    localparam logic [LOW_W-1:0] M_WR_MASK = 23'h7FF9AB;
    // Supervisor-writable bits: 0,1,5,8,13-16,18,19.
    localparam logic [LOW_W-1:0] S_WR_MASK = 23'h0DE123;
    // Supervisor-readable low bits: the writable set plus bit 4.
    localparam logic [LOW_W-1:0] S_RD_MASK = 23'h0DE133;

    typedef struct packed {
        logic [LOW_W-1:0] low;
        logic [1:0]       sxl;
        logic [1:0]       uxl;
    } mstat_state_t;

endpackage

// File: rtl/mstat_legalize.sv
module mstat_legalize
    import mstat_pkg::*;
(
    input  logic             we,
    input  logic             sup,
    input  logic [LOW_W-1:0] cur_low,
    input  logic [LOW_W-1:0] wr_low,
    output logic [LOW_W-1:0] nxt_low
);

    logic [LOW_W-1:0] mask;
    logic [LOW_W-1:0] merged;

    always_comb begin
        mask   = sup ? S_WR_MASK : M_WR_MASK;
        merged = (cur_low & ~mask) | (wr_low & mask);
        // Reserved previous-privilege code: keep the old value.
        if (!sup && (wr_low[B_MPP_HI:B_MPP_LO] == MPP_RSV)) begin
            merged[B_MPP_HI:B_MPP_LO] = cur_low[B_MPP_HI:B_MPP_LO];
        end
        merged[B_UPIE] = 1'b0;
        nxt_low = we ? merged : cur_low;
    end

endmodule

// File: rtl/mstat_view.sv
module mstat_view
    import mstat_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             sup,
    input  logic [LOW_W-1:0] low,
    input  logic [1:0]       sxl,
    input  logic [1:0]       uxl,
    output logic [XLEN-1:0]  rdata
);

    localparam int GAP_W = XLEN - 1 - LOW_W;

    logic             sd;
    logic [XLEN-1:0]  wfield_m;
    logic [XLEN-1:0]  wfield_s;
    logic [XLEN-1:0]  full_m;
    logic [XLEN-1:0]  full_s;

    generate
        if (XLEN == 64) begin : g_wide
            assign wfield_m = {28'b0, sxl, uxl, 32'b0};
            assign wfield_s = {30'b0, uxl, 32'b0};
        end else begin : g_narrow
            logic unused_width;
            assign unused_width = ^{sxl, uxl};
            assign wfield_m = '0;
            assign wfield_s = '0;
        end
    endgenerate

    always_comb begin
        sd = (low[B_XS_HI:B_XS_LO] == EXT_DIRTY) ||
             (low[B_FS_HI:B_FS_LO] == EXT_DIRTY);
        full_m = {sd, {GAP_W{1'b0}}, low} | wfield_m;
        full_s = {sd, {GAP_W{1'b0}}, low & S_RD_MASK} | wfield_s;
        rdata  = sup ? full_s : full_m;
    end

endmodule

// File: rtl/mstat_xlat.sv
module mstat_xlat
    import mstat_pkg::*;
(
    input  priv_e       priv,
    input  logic [1:0]  mxl,
    input  logic [1:0]  sxl,
    input  logic [1:0]  uxl,
    input  logic        tvm,
    input  logic [3:0]  satp_mode,
    output logic [1:0]  eff_xl,
    output logic        fence_illegal,
    output logic [3:0]  xlat_mode
);

    logic lower_priv;
    logic sup_wide;

    always_comb begin
        lower_priv = (priv == PRIV_U) || (priv == PRIV_S);
        sup_wide   = (sxl == XL_64);

        unique case (priv)
            PRIV_U:  eff_xl = uxl;
            PRIV_S:  eff_xl = sxl;
            default: eff_xl = mxl;
        endcase

        fence_illegal = (priv == PRIV_U) ||
                        ((priv == PRIV_S) && tvm && sup_wide);

        if (!lower_priv) begin
            xlat_mode = 4'd0;
        end else if (sup_wide) begin
            xlat_mode = satp_mode;
        end else begin
            xlat_mode = {3'b000, satp_mode[0]};
        end
    end

endmodule

// File: rtl/mstat_csr.sv
module mstat_csr
    import mstat_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic            csr_sel_sup,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [1:0]      cur_priv,
    input  logic [1:0]      misa_mxl,
    input  logic [3:0]      satp_mode,
    output logic [XLEN-1:0] csr_rdata,
    output logic [1:0]      eff_xl,
    output logic            fence_illegal,
    output logic [3:0]      xlat_mode
);

    localparam bit WIDE = (XLEN == 64);

    mstat_state_t state_d;
    mstat_state_t state_q;
    logic [LOW_W-1:0] nxt_low;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^csr_wdata[XLEN-1:LOW_W];

    mstat_legalize u_legal (
        .we      (csr_we),
        .sup     (csr_sel_sup),
        .cur_low (state_q.low),
        .wr_low  (csr_wdata[LOW_W-1:0]),
        .nxt_low (nxt_low)
    );

    always_comb begin
        state_d     = state_q;
        state_d.low = nxt_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.low <= '0;
            state_q.sxl <= WIDE ? misa_mxl : XL_32;
            state_q.uxl <= WIDE ? misa_mxl : XL_32;
        end else begin
            state_q <= state_d;
        end
    end

    mstat_view #(.XLEN(XLEN)) u_view (
        .sup   (csr_sel_sup),
        .low   (state_q.low),
        .sxl   (state_q.sxl),
        .uxl   (state_q.uxl),
        .rdata (csr_rdata)
    );

    mstat_xlat u_xlat (
        .priv          (priv_e'(cur_priv)),
        .mxl           (misa_mxl),
        .sxl           (state_q.sxl),
        .uxl           (state_q.uxl),
        .tvm           (state_q.low[B_TVM]),
        .satp_mode     (satp_mode),
        .eff_xl        (eff_xl),
        .fence_illegal (fence_illegal),
        .xlat_mode     (xlat_mode)
    );

    // R2
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> (state_q.sxl == $past(state_q.sxl)) &&
                   (state_q.uxl == $past(state_q.uxl)));

    // R3
    upie_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[B_UPIE] == 1'b0);

    // R4
    sd_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[XLEN-1] == ((state_q.low[B_XS_HI:B_XS_LO] == EXT_DIRTY) ||
                              (state_q.low[B_FS_HI:B_FS_LO] == EXT_DIRTY)));

    // R7
    sup_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel_sup) |=>
            ((state_q.low & ~S_WR_MASK) == $past(state_q.low & ~S_WR_MASK)));

    // R9
    user_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == PRIV_U) |-> fence_illegal);

    // R10
    mach_bare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == PRIV_M) |-> (xlat_mode == 4'd0));

endmodule

// File: tb/mstat_csr_tb.sv
`timescale 1ns/1ps
module mstat_csr_tb_top;

    typedef struct packed {
        logic        sup;
        logic [63:0] wd;
        logic [63:0] em;
        logic [63:0] es;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_000A_007F_F9AB, 64'h8000_0002_000D_E123},
        '{1'b0, 64'h0000_0000_0000_0000, 64'h0000_000A_0000_0000, 64'h0000_0002_0000_0000},
        '{1'b0, 64'h0000_0000_0000_1800, 64'h0000_000A_0000_1800, 64'h0000_0002_0000_0000},
        '{1'b0, 64'h0000_0000_0000_1008, 64'h0000_000A_0000_1808, 64'h0000_0002_0000_0000},
        '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_000A_000D_F92B, 64'h8000_0002_000D_E123},
        '{1'b1, 64'h0000_0000_0000_0000, 64'h0000_000A_0000_1808, 64'h0000_0002_0000_0000},
        '{1'b0, 64'h0000_0000_0000_6000, 64'h8000_000A_0000_6000, 64'h8000_0002_0000_6000},
        '{1'b0, 64'h0000_0000_0001_8000, 64'h8000_000A_0001_8000, 64'h8000_0002_0001_8000},
        '{1'b0, 64'h0000_0000_0000_2000, 64'h0000_000A_0000_2000, 64'h0000_0002_0000_2000},
        '{1'b0, 64'h0000_0000_0000_0010, 64'h0000_000A_0000_0000, 64'h0000_0002_0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_priv = 2'b11;
    logic [3:0]  satp_mode = 4'd0;

    logic        we64 = 1'b0, sel64 = 1'b0;
    logic [63:0] wd64 = '0;
    logic [1:0]  mxl64 = 2'b10;
    logic [63:0] rd64;
    logic [1:0]  xl64;
    logic        fi64;
    logic [3:0]  xm64;

    logic        we32 = 1'b0, sel32 = 1'b0;
    logic [31:0] wd32 = '0;
    logic [1:0]  mxl32 = 2'b01;
    logic [31:0] rd32;
    logic [1:0]  xl32;
    logic        fi32;
    logic [3:0]  xm32;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mstat_csr #(.XLEN(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(we64), .csr_sel_sup(sel64),
        .csr_wdata(wd64), .cur_priv(cur_priv), .misa_mxl(mxl64),
        .satp_mode(satp_mode), .csr_rdata(rd64), .eff_xl(xl64),
        .fence_illegal(fi64), .xlat_mode(xm64)
    );

    mstat_csr #(.XLEN(32)) dut32_i (
        .clk(clk), .rst_n(rst_n), .csr_we(we32), .csr_sel_sup(sel32),
        .csr_wdata(wd32), .cur_priv(cur_priv), .misa_mxl(mxl32),
        .satp_mode(satp_mode), .csr_rdata(rd32), .eff_xl(xl32),
        .fence_illegal(fi32), .xlat_mode(xm32)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr64(input logic sup, input logic [63:0] d);
        @(negedge clk);
        we64 = 1'b1; sel64 = sup; wd64 = d;
        @(negedge clk);
        we64 = 1'b0; wd64 = '0;
    endtask

    task automatic wr32(input logic sup, input logic [31:0] d);
        @(negedge clk);
        we32 = 1'b1; sel32 = sup; wd32 = d;
        @(negedge clk);
        we32 = 1'b0; wd32 = '0;
    endtask

    task automatic setp(input logic [1:0] p, input logic [3:0] m);
        @(negedge clk);
        cur_priv = p; satp_mode = m;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        sel64 = 1'b0; #1;
        chk("R1 reset machine view", rd64, 64'h0000_000A_0000_0000);
        sel64 = 1'b1; #1;
        chk("R1 R6 reset supervisor view", rd64, 64'h0000_0002_0000_0000);
        sel32 = 1'b0; #1;
        chk("R11 reset 32-bit view", {32'b0, rd32}, 64'd0);

        // R2 R3 R4 R5 R6 R7: vector walk
        for (int i = 0; i < NVEC; i++) begin
            wr64(VEC[i].sup, VEC[i].wd);
            sel64 = 1'b0; #1;
            chk($sformatf("R2 R3 R4 R5 R7 vec%0d machine", i), rd64, VEC[i].em);
            sel64 = 1'b1; #1;
            chk($sformatf("R6 vec%0d supervisor", i), rd64, VEC[i].es);
        end
        sel64 = 1'b0;

        // R8 effective width per privilege
        setp(2'b11, 4'd0); chk("R8 machine width", {62'b0, xl64}, 64'd2);
        setp(2'b01, 4'd0); chk("R8 supervisor width", {62'b0, xl64}, 64'd2);
        setp(2'b00, 4'd0); chk("R8 user width", {62'b0, xl64}, 64'd2);
        @(negedge clk); mxl64 = 2'b01;
        setp(2'b11, 4'd0); chk("R8 machine follows mxl", {62'b0, xl64}, 64'd1);
        setp(2'b01, 4'd0); chk("R2 supervisor width held", {62'b0, xl64}, 64'd2);
        setp(2'b10, 4'd0); chk("R8 reserved priv as machine", {62'b0, xl64}, 64'd1);

        // R9 fence legality
        wr64(1'b0, 64'h0000_0000_0010_0000);
        setp(2'b01, 4'd0); chk("R9 supervisor with trap bit", {63'b0, fi64}, 64'd1);
        setp(2'b00, 4'd0); chk("R9 user", {63'b0, fi64}, 64'd1);
        setp(2'b11, 4'd0); chk("R9 machine", {63'b0, fi64}, 64'd0);
        wr64(1'b0, 64'd0);
        setp(2'b01, 4'd0); chk("R9 supervisor clear", {63'b0, fi64}, 64'd0);

        // R10 translation mode
        setp(2'b11, 4'd8); chk("R10 machine bare", {60'b0, xm64}, 64'd0);
        setp(2'b01, 4'd8); chk("R10 supervisor mode", {60'b0, xm64}, 64'd8);
        setp(2'b00, 4'd9); chk("R10 user mode", {60'b0, xm64}, 64'd9);

        // R11 32-bit configuration
        wr32(1'b0, 32'hFFFF_FFFF);
        sel32 = 1'b0; #1;
        chk("R11 R4 32-bit machine", {32'b0, rd32}, 64'h807F_F9AB);
        sel32 = 1'b1; #1;
        chk("R11 R6 32-bit supervisor", {32'b0, rd32}, 64'h800D_E123);
        setp(2'b01, 4'd1);
        chk("R11 supervisor width", {62'b0, xl32}, 64'd1);
        chk("R9 32-bit supervisor trap bit ignored", {63'b0, fi32}, 64'd0);
        chk("R10 32-bit mode bit0", {60'b0, xm32}, 64'd1);
        setp(2'b00, 4'd8);
        chk("R11 user width", {62'b0, xl32}, 64'd1);
        chk("R9 32-bit user", {63'b0, fi32}, 64'd1);
        chk("R10 32-bit mode upper ignored", {60'b0, xm32}, 64'd0);
        setp(2'b11, 4'd9);
        chk("R8 32-bit machine width", {62'b0, xl32}, 64'd1);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule